// File: doc/BRIEF.md
# Accumulator ALU Unit for a Shared-Bus Teaching Machine

This unit is the arithmetic end of a minimal accumulator computer whose blocks talk over one 8-bit shared bus. It holds the accumulator (the first operand), a temporary register that takes the second operand from the bus, a function register, a result latch, and zero and carry flags. A sequencer drives a 4-bit operation code together with a strobe. On each strobed cycle the unit does one of a few bus actions. It can take the function from the upper nibble of an instruction byte, load the accumulator or the temporary register from the bus, or compute into the result latch. It can also put the accumulator on the bus, or move the result latch over the bus back into the accumulator.

Computing and write-back take separate states, so the result is visible on the bus before the accumulator changes. The carry variants of add and subtract use the carry flag that a previous operation left behind. The zero flag feeds a jump-if-not-zero decision elsewhere, and the carry flag feeds a jump-if-no-carry decision. The bus has no flow control: the unit must take or give a byte in the strobed cycle itself. It releases the bus (drives zeros with its drive flag low) whenever it is not reading out.

Top module: `sap_alu_unit`

## Requirements
- R1: After reset the accumulator, temporary register, function select, result latch and both flags are zero, and `bus_drive` is low.
- R2: `bus_drive` is high, and `bus_out` carries a value, only in a cycle with `op_stb` high and `op_code` 3 (accumulator read-out, `bus_out` = accumulator) or 6 (result transfer, `bus_out` = result latch); otherwise `bus_out` is 0.
- R3: Op code 2 loads the accumulator from `bus_in` at the clock edge; `flag_zero` then shows whether the loaded byte is zero.
- R4: Op code 1 latches `bus_in[7:4]` as the function select; `bus_in[3:0]` is ignored.
- R5: Op code 5 writes the function of accumulator and temporary register (op code 4 loads the temporary register) into the result latch; the accumulator keeps its value until a transfer.
- R6: Function 0 (ADD) gives acc+tmp and function 1 (ADDC) gives acc+tmp+carry; the carry flag takes the carry-out of bit 7.
- R7: Function 2 (SUB) gives acc-tmp and function 3 (SUBC) gives acc+~tmp+carry; the carry flag is 1 when no borrow occurred.
- R8: Functions 4, 5, 6 and 7 give AND, OR, XOR and NOT of the accumulator (NOT ignores the temporary register); the carry flag is unchanged.
- R9: Op code 6 drives the result latch onto the bus and loads it into the accumulator at the same edge, with the zero flag updated from it.
- R10: With `op_stb` low, or with op codes 0 and 7 to 15, no register or flag changes and the bus is released; functions 8 to 15 copy the accumulator into the result latch and leave carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_stb | input | 1 | Qualifies `op_code` for this cycle |
| op_code | input | 4 | Bus action from the sequencer |
| bus_in | input | 8 | Byte present on the shared bus |
| bus_out | output | 8 | Byte this unit puts on the bus, 0 when released |
| bus_drive | output | 1 | High while this unit owns the bus |
| flag_zero | output | 1 | Accumulator is zero after its last load |
| flag_carry | output | 1 | Carry out, or inverted borrow, of the last arithmetic function |

## Verification
Two functions share one cycle in this block. In a transfer the latch drives the bus while the accumulator and zero flag take that same byte. In ADDC or SUBC the carry flag is read as carry-in and rewritten with the new carry-out at the same edge. The bench provokes the first with transfers of zero and non-zero results, judging the read-out byte, a later accumulator read and the zero flag. For the second it presets carry to both values by a preceding ADD or SUB and checks the sum and the new carry against a model built from the requirements.

// File: rtl/sap_alu_pkg.sv
package sap_alu_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_IDLE   = 4'd0,
    OP_SET_FN = 4'd1,
    OP_LD_ACC = 4'd2,
    OP_RD_ACC = 4'd3,
    OP_LD_TMP = 4'd4,
    OP_EXEC   = 4'd5,
    OP_XFER   = 4'd6
  } bus_op_e;

  typedef enum logic [CODE_W-1:0] {
    FN_ADD  = 4'd0,
    FN_ADDC = 4'd1,
    FN_SUB  = 4'd2,
    FN_SUBC = 4'd3,
    FN_AND  = 4'd4,
    FN_OR   = 4'd5,
    FN_XOR  = 4'd6,
    FN_NOT  = 4'd7
  } alu_fn_e;

  typedef struct packed {
    logic set_fn;
    logic ld_acc;
    logic rd_acc;
    logic ld_tmp;
    logic exec;
    logic xfer;
  } alu_ctl_s;
endpackage

// File: rtl/sap_alu_decode.sv
module sap_alu_decode
  import sap_alu_pkg::*;
(
  input  logic              op_stb,
  input  logic [CODE_W-1:0] op_code,
  output alu_ctl_s          ctl
);
  always_comb begin
    ctl = '0;
    if (op_stb) begin
      case (op_code)
        OP_SET_FN: ctl.set_fn = 1'b1;
        OP_LD_ACC: ctl.ld_acc = 1'b1;
        OP_RD_ACC: ctl.rd_acc = 1'b1;
        OP_LD_TMP: ctl.ld_tmp = 1'b1;
        OP_EXEC:   ctl.exec   = 1'b1;
        OP_XFER:   ctl.xfer   = 1'b1;
        default:   ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/sap_alu_core.sv
module sap_alu_core
  import sap_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [CODE_W-1:0] fn,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              cout,
  output logic              carry_wr
);
  logic          subtract;
  logic          c_eff;
  logic [W-1:0]  b_eff;
  logic [W:0]    sum;

  always_comb begin
    subtract = (fn == FN_SUB) || (fn == FN_SUBC);
    case (fn)
      FN_ADD:  c_eff = 1'b0;
      FN_SUB:  c_eff = 1'b1;
      default: c_eff = cin;
    endcase
    b_eff = subtract ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  end

  always_comb begin
    carry_wr = 1'b0;
    cout     = cin;
    case (fn)
      FN_ADD, FN_ADDC, FN_SUB, FN_SUBC: begin
        res      = sum[W-1:0];
        cout     = sum[W];
        carry_wr = 1'b1;
      end
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_XOR:  res = a ^ b;
      FN_NOT:  res = ~a;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/sap_alu_busdrv.sv
module sap_alu_busdrv #(
  parameter int W = 8
) (
  input  logic         sel_acc,
  input  logic         sel_res,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] res,
  output logic [W-1:0] bus_out,
  output logic         bus_drive
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign bus_out[i] = (sel_acc & acc[i]) | (sel_res & res[i]);
    end
  endgenerate
  assign bus_drive = sel_acc | sel_res;
endmodule

// File: rtl/sap_alu_unit.sv
module sap_alu_unit
  import sap_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_stb,
  input  logic [CODE_W-1:0] op_code,
  input  logic [W-1:0]      bus_in,
  output logic [W-1:0]      bus_out,
  output logic              bus_drive,
  output logic              flag_zero,
  output logic              flag_carry
);
  localparam int FN_LO = W - CODE_W;

  alu_ctl_s          ctl;
  logic [W-1:0]      acc_q, tmp_q, res_q, res_d;
  logic [CODE_W-1:0] fn_q;
  logic              cout_d, carry_wr;

  sap_alu_decode u_dec (
    .op_stb  (op_stb),
    .op_code (op_code),
    .ctl     (ctl)
  );

  sap_alu_core #(.W(W)) u_core (
    .fn       (fn_q),
    .a        (acc_q),
    .b        (tmp_q),
    .cin      (flag_carry),
    .res      (res_d),
    .cout     (cout_d),
    .carry_wr (carry_wr)
  );

  sap_alu_busdrv #(.W(W)) u_drv (
    .sel_acc   (ctl.rd_acc),
    .sel_res   (ctl.xfer),
    .acc       (acc_q),
    .res       (res_q),
    .bus_out   (bus_out),
    .bus_drive (bus_drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      tmp_q      <= '0;
      res_q      <= '0;
      fn_q       <= '0;
      flag_zero  <= 1'b0;
      flag_carry <= 1'b0;
    end else begin
      if (ctl.set_fn) fn_q  <= bus_in[W-1:FN_LO];
      if (ctl.ld_tmp) tmp_q <= bus_in;
      if (ctl.ld_acc) begin
        acc_q     <= bus_in;
        flag_zero <= (bus_in == '0);
      end
      if (ctl.xfer) begin
        acc_q     <= res_q;
        flag_zero <= (res_q == '0);
      end
      if (ctl.exec) begin
        res_q <= res_d;
        if (carry_wr) flag_carry <= cout_d;
      end
    end
  end
endmodule

// File: rtl/sap_alu_chk.sv
module sap_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_stb,
  input logic [3:0]   op_code,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_drive,
  input logic         flag_zero,
  input logic         flag_carry,
  input logic [3:0]   fn_sel
);
  // R2
  no_strobe_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_stb |-> !bus_drive);

  // R2
  released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_out == '0));

  // R3
  zero_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 4'd2) |=> (flag_zero == ($past(bus_in) == '0)));

  // R9
  zero_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 4'd6) |=> (flag_zero == ($past(bus_out) == '0)));

  // R8
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && op_code == 4'd5 && fn_sel[3:2] != 2'b00) |=> $stable(flag_carry));

  // R10
  idle_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_stb |=> ($stable(flag_zero) && $stable(flag_carry)));
endmodule

bind sap_alu_unit sap_alu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_stb     (op_stb),
  .op_code    (op_code),
  .bus_in     (bus_in),
  .bus_out    (bus_out),
  .bus_drive  (bus_drive),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry),
  .fn_sel     (fn_q)
);

// File: tb/test_sap_alu_unit.sv
module test_sap_alu_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_stb = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] bus_in = 8'd0;
  logic [7:0] bus_out;
  logic       bus_drive, flag_zero, flag_carry;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] last_out;
  logic       last_drv;

  always #5 clk = ~clk;

  sap_alu_unit i_sap_alu_unit (
    .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_code(op_code),
    .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .flag_zero(flag_zero), .flag_carry(flag_carry)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one strobed (or unstrobed) cycle; bus outputs captured mid-cycle
  task automatic cyc(input bit stb, input logic [3:0] c, input logic [7:0] d);
    @(negedge clk);
    op_stb = stb; op_code = c; bus_in = d;
    #1;
    last_out = bus_out; last_drv = bus_drive;
    @(negedge clk);
    op_stb = 1'b0; op_code = 4'd0; bus_in = 8'd0;
  endtask

  task automatic read_acc(output logic [7:0] v);
    cyc(1, 4'd3, 8'h00);
    v = last_out;
  endtask

  // model from requirements: {carry, result}
  function automatic logic [8:0] model(input logic [3:0] f, input logic [7:0] a,
                                       input logic [7:0] b, input logic c);
    logic [8:0] s;
    case (f)
      4'd0: s = {1'b0, a} + {1'b0, b};
      4'd1: s = {1'b0, a} + {1'b0, b} + {8'd0, c};
      4'd2: s = {1'b0, a} + {1'b0, ~b} + 9'd1;
      4'd3: s = {1'b0, a} + {1'b0, ~b} + {8'd0, c};
      4'd4: s = {c, a & b};
      4'd5: s = {c, a | b};
      4'd6: s = {c, a ^ b};
      4'd7: s = {c, ~a};
      default: s = {c, a};
    endcase
    return s;
  endfunction

  task automatic run_fn(input string req, input logic [3:0] f, input logic [7:0] a,
                        input logic [7:0] b);
    logic [8:0] e;
    logic [7:0] v;
    e = model(f, a, b, flag_carry);
    cyc(1, 4'd1, {f, 4'hA});
    cyc(1, 4'd2, a);
    cyc(1, 4'd4, b);
    cyc(1, 4'd5, 8'h00);
    cyc(1, 4'd6, 8'h00);
    chk({req, " xfer drive"}, last_drv, 1);
    chk({req, " result"}, last_out, e[7:0]);
    chk({req, " carry"}, flag_carry, e[8]);
    chk({req, " zero"}, flag_zero, (e[7:0] == 8'h00));
    read_acc(v);
    chk({req, " acc reloaded"}, v, e[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 zero flag", flag_zero, 0);
    chk("R1 carry flag", flag_carry, 0);
    chk("R1 drive", bus_drive, 0);
    read_acc(v);
    chk("R1 acc", v, 0);
    chk("R2 rd drive", last_drv, 1);
    cyc(1, 4'd5, 8'h00);
    cyc(1, 4'd6, 8'h00);
    chk("R1 result latch", last_out, 0);
  endtask

  task automatic t_load_zero;
    logic [7:0] v;
    cyc(1, 4'd2, 8'h00);
    chk("R3 zero set", flag_zero, 1);
    cyc(1, 4'd2, 8'h5C);
    chk("R3 zero clear", flag_zero, 0);
    chk("R2 no drive on load", last_drv, 0);
    chk("R2 released bus", last_out, 0);
    read_acc(v);
    chk("R3 acc value", v, 8'h5C);
  endtask

  task automatic t_add;
    run_fn("R6 ADD", 4'd0, 8'h3C, 8'h11);
    run_fn("R6 ADD ovf", 4'd0, 8'hF0, 8'h20);
    run_fn("R6 ADDC cin1", 4'd1, 8'h01, 8'h01);
    run_fn("R6 ADDC cin0", 4'd1, 8'hFF, 8'h01);
  endtask

  task automatic t_sub;
    run_fn("R7 SUB", 4'd2, 8'h50, 8'h20);
    run_fn("R7 SUB borrow", 4'd2, 8'h10, 8'h20);
    run_fn("R7 SUBC cin0", 4'd3, 8'h10, 8'h05);
    run_fn("R7 SUBC cin1", 4'd3, 8'h10, 8'h05);
    run_fn("R7 R9 SUB equal", 4'd2, 8'h33, 8'h33);
  endtask

  task automatic t_logic;
    run_fn("R8 AND", 4'd4, 8'hCC, 8'hAA);
    run_fn("R8 OR", 4'd5, 8'hCC, 8'hAA);
    run_fn("R8 XOR", 4'd6, 8'hCC, 8'hAA);
    run_fn("R8 NOT", 4'd7, 8'h5A, 8'hFF);
    run_fn("R8 NOT to zero", 4'd7, 8'hFF, 8'h00);
  endtask

  task automatic t_fn_latch;
    logic [7:0] v;
    // R4: low nibble 0x5 must not matter; upper nibble 2 selects SUB
    cyc(1, 4'd1, 8'h25);
    cyc(1, 4'd2, 8'h09);
    cyc(1, 4'd4, 8'h04);
    cyc(1, 4'd5, 8'h00);
    read_acc(v);
    chk("R5 acc kept after exec", v, 8'h09);
    cyc(1, 4'd6, 8'h00);
    chk("R4 upper nibble select", last_out, 8'h05);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    logic zf, cf;
    cyc(1, 4'd2, 8'h77);
    zf = flag_zero; cf = flag_carry;
    cyc(0, 4'd2, 8'h00);
    chk("R10 unstrobed no drive", last_drv, 0);
    for (int c = 7; c < 16; c++) begin
      cyc(1, c[3:0], 8'h00);
      chk("R10 unused code no drive", last_drv, 0);
    end
    cyc(1, 4'd0, 8'h00);
    chk("R10 idle code no drive", last_out, 0);
    read_acc(v);
    chk("R10 acc unchanged", v, 8'h77);
    chk("R10 zero unchanged", flag_zero, zf);
    chk("R10 carry unchanged", flag_carry, cf);
    run_fn("R10 pass func", 4'd9, 8'h77, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_zero();
    t_add();
    t_sub();
    t_logic();
    t_fn_latch();
    t_ignore();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule